// File: doc/BRIEF.md
# Legacy PC Physical Memory Router

This block sits between a CPU-side byte port and the targets of a legacy PC physical address space. Each cycle it takes one byte access (a read strobe, a write strobe or neither), masks address line 20 when the A20 gate is off, and routes the access to main RAM, a video memory port, a boot ROM array or one of two interrupt-controller register windows. It can also drop the access. Selection is combinational from the masked address, so the targets see their select, shared address and write data in the same cycle as the strobe. Each target returns its read byte in that same cycle, and the router registers the chosen byte on the next rising edge.

Inside the legacy window from 512 KB to 1 MB each region has its own rule. The lower 128 KB is plain RAM. The next 128 KB goes to video memory. The top 256 KB is split into sixteen 16 KB segments, and each segment has one shadow code for reads and another for writes. Accesses at or above the installed memory size are offered to the interrupt-controller windows. If neither window claims them, a read returns all ones and a write is dropped. A reserved shadow code sets a sticky error flag, which only reset clears.

Top module: `pc_mem_router`

## Requirements
- R1: With `a20_en` low, bit 20 of the address is cleared before any decode, and `tgt_addr` carries the masked address (for example 0x1A0000 decodes as video memory).
- R2: A masked address below `MEM_BYTES` whose bits 31:19 are not 1 selects RAM, and `tgt_we` follows the write strobe.
- R3: Masked addresses 0x80000 to 0x9FFFF below `MEM_BYTES` select RAM for reads and writes.
- R4: Masked addresses 0xA0000 to 0xBFFFF below `MEM_BYTES` select the video port for reads and writes.
- R5: With `shadow_en` high, an access to 0xC0000 to 0xFFFFF uses segment s = address bits 17:14. A read takes its code from `shd_rd_tbl[2s+1:2s]` and a write from `shd_wr_tbl[2s+1:2s]`, each independently of the other table.
- R6: Write code 0 writes the byte to RAM. Write code 1 asserts no select and no `tgt_we`, and does not set `err`.
- R7: Read code 0 reads RAM. Read code 1 selects the ROM with `rom_addr` = masked address minus 0xC0000, and the ROM is never written.
- R8: With `shadow_en` low, reads from 0xC0000 to 0xFFFFF select RAM and writes there assert no select.
- R9: A masked address at or above `MEM_BYTES` that neither window claims asserts no select. A read there returns 0xFF.
- R10: At or above `MEM_BYTES`, the 4 KB window at `LIC_BASE` asserts `lic_cs` and the 4 KB window at `IOC_BASE` asserts `ioc_cs`. The `LIC_BASE` window is checked first, and at most one select is active at a time.
- R11: Shadow code 2 or 3 for the access in use asserts no select, returns 0xFF on a read, and sets `err`, which stays set until reset.
- R12: `rdata` loads the selected byte on the rising edge where `rd_stb` is high and `wr_stb` is low. It holds otherwise. With both strobes high the access is a write.
- R13: Synchronous reset clears `rdata` to 0 and `err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Physical byte address |
| rd_stb | input | 1 | Read request this cycle |
| wr_stb | input | 1 | Write request this cycle |
| wdata | input | DATA_W | Write byte |
| a20_en | input | 1 | A20 gate: low forces address bit 20 to zero |
| shadow_en | input | 1 | Enables the per-segment shadow codes |
| shd_rd_tbl | input | 32 | Read codes, 2 bits per segment, segment s at [2s+1:2s] |
| shd_wr_tbl | input | 32 | Write codes, same layout |
| tgt_addr | output | ADDR_W | Masked address to all targets |
| tgt_wdata | output | DATA_W | Write byte to all targets |
| tgt_we | output | 1 | Write enable for the selected target |
| ram_cs | output | 1 | Main RAM select |
| vid_cs | output | 1 | Video memory select |
| rom_cs | output | 1 | Boot ROM select |
| rom_addr | output | 18 | ROM byte offset from 0xC0000 |
| lic_cs | output | 1 | Local interrupt-controller window select |
| ioc_cs | output | 1 | I/O interrupt-controller window select |
| ram_rdata | input | DATA_W | RAM read byte |
| vid_rdata | input | DATA_W | Video read byte |
| rom_rdata | input | DATA_W | ROM read byte |
| lic_rdata | input | DATA_W | Local controller read byte |
| ioc_rdata | input | DATA_W | I/O controller read byte |
| rdata | output | DATA_W | Registered read byte |
| err | output | 1 | Sticky reserved-code flag |

## Verification
The hardest case to reach is a segment whose read code and write code differ while shadowing is on. Random addresses seldom land in the same 16 KB segment for both directions while the tables happen to disagree. Directed accesses therefore program opposite codes into chosen segments and hit each one with both a read and a write. Random phases then mix these with A20-aliased addresses, boundary addresses around the installed size and the controller windows. The sticky error flag is exercised last, after reset, so that it does not hide the no-error outcome of inhibited writes.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int SEG_LOG2   = 14;
  localparam int UPPER_LOG2 = 18;
  localparam int HOLE_LOG2  = 19;
  localparam int A20_BIT    = 20;
  localparam int SEG_IW     = UPPER_LOG2 - SEG_LOG2;
  localparam int N_SEG      = 1 << SEG_IW;
  localparam int SHD_W      = 2;
  localparam int TBL_W      = N_SEG * SHD_W;
  localparam int ROM_AW     = UPPER_LOG2;

  typedef enum logic [1:0] {
    SHD_RAM  = 2'd0,
    SHD_ROM  = 2'd1,
    SHD_RSV2 = 2'd2,
    SHD_RSV3 = 2'd3
  } shd_code_e;

  typedef enum logic [1:0] {
    REG_PLAIN,
    REG_LOW,
    REG_VID,
    REG_UPPER
  } region_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_VID,
    TGT_ROM,
    TGT_LIC,
    TGT_IOC,
    TGT_BAD
  } tgt_e;

  typedef struct packed {
    logic              above;
    logic              lic_hit;
    logic              ioc_hit;
    region_e           region;
    logic [SEG_IW-1:0] seg;
  } dec_t;
endpackage

// File: rtl/pmr_addr_decode.sv
module pmr_addr_decode
  import pmr_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] LIC_BASE  = 32'hFEE0_0000,
  parameter logic [ADDR_W-1:0] IOC_BASE  = 32'hFEC0_0000,
  parameter int                WIN_LOG2  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              a20_en,
  output logic [ADDR_W-1:0] masked,
  output dec_t              dec
);
  localparam int TAG_W = ADDR_W - HOLE_LOG2;
  localparam logic [TAG_W-1:0] HOLE_TAG = TAG_W'(1);

  logic in_hole;

  // Gate line 20 before anything looks at the address
  always_comb begin
    masked = addr;
    if (!a20_en) masked[A20_BIT] = 1'b0;
  end

  assign in_hole = (masked[ADDR_W-1:HOLE_LOG2] == HOLE_TAG);

  always_comb begin
    dec.above   = (masked >= MEM_BYTES);
    dec.lic_hit = (masked[ADDR_W-1:WIN_LOG2] == LIC_BASE[ADDR_W-1:WIN_LOG2]);
    dec.ioc_hit = (masked[ADDR_W-1:WIN_LOG2] == IOC_BASE[ADDR_W-1:WIN_LOG2]);
    dec.seg     = masked[UPPER_LOG2-1:SEG_LOG2];
    if (!in_hole) begin
      dec.region = REG_PLAIN;
    end else begin
      case (masked[HOLE_LOG2-1:HOLE_LOG2-2])
        2'b00:   dec.region = REG_LOW;
        2'b01:   dec.region = REG_VID;
        default: dec.region = REG_UPPER;
      endcase
    end
  end
endmodule

// File: rtl/pmr_shadow_lookup.sv
module pmr_shadow_lookup
  import pmr_pkg::*;
(
  input  logic [TBL_W-1:0]  rd_tbl,
  input  logic [TBL_W-1:0]  wr_tbl,
  input  logic [SEG_IW-1:0] seg,
  output shd_code_e         rd_code,
  output shd_code_e         wr_code
);
  logic [SHD_W-1:0] rd_ent [N_SEG];
  logic [SHD_W-1:0] wr_ent [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    assign rd_ent[g] = rd_tbl[g*SHD_W +: SHD_W];
    assign wr_ent[g] = wr_tbl[g*SHD_W +: SHD_W];
  end

  assign rd_code = shd_code_e'(rd_ent[seg]);
  assign wr_code = shd_code_e'(wr_ent[seg]);
endmodule

// File: rtl/pmr_route.sv
module pmr_route
  import pmr_pkg::*;
(
  input  logic      rd_stb,
  input  logic      wr_stb,
  input  logic      shadow_en,
  input  dec_t      dec,
  input  shd_code_e rd_code,
  input  shd_code_e wr_code,
  output tgt_e      tgt
);
  shd_code_e code;

  assign code = wr_stb ? wr_code : rd_code;

  always_comb begin
    tgt = TGT_NONE;
    if (rd_stb || wr_stb) begin
      if (dec.above) begin
        // Windows only claim what lies past installed memory; local first
        if (dec.lic_hit)      tgt = TGT_LIC;
        else if (dec.ioc_hit) tgt = TGT_IOC;
      end else begin
        case (dec.region)
          REG_PLAIN, REG_LOW: tgt = TGT_RAM;
          REG_VID:            tgt = TGT_VID;
          default: begin
            if (!shadow_en) begin
              tgt = wr_stb ? TGT_NONE : TGT_RAM;
            end else begin
              case (code)
                SHD_RAM: tgt = TGT_RAM;
                SHD_ROM: tgt = wr_stb ? TGT_NONE : TGT_ROM;
                default: tgt = TGT_BAD;
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pmr_rdata_reg.sv
module pmr_rdata_reg
  import pmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] vid_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] lic_rdata,
  input  logic [DATA_W-1:0] ioc_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    case (tgt)
      TGT_RAM: pick = ram_rdata;
      TGT_VID: pick = vid_rdata;
      TGT_ROM: pick = rom_rdata;
      TGT_LIC: pick = lic_rdata;
      TGT_IOC: pick = ioc_rdata;
      default: pick = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (capture)        rdata <= pick;
      if (tgt == TGT_BAD) err   <= 1'b1;
    end
  end
endmodule

// File: rtl/pc_mem_router.sv
module pc_mem_router
  import pmr_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] LIC_BASE  = 32'hFEE0_0000,
  parameter logic [ADDR_W-1:0] IOC_BASE  = 32'hFEC0_0000,
  parameter int                WIN_LOG2  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              a20_en,
  input  logic              shadow_en,
  input  logic [TBL_W-1:0]  shd_rd_tbl,
  input  logic [TBL_W-1:0]  shd_wr_tbl,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              tgt_we,
  output logic              ram_cs,
  output logic              vid_cs,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              lic_cs,
  output logic              ioc_cs,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] vid_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] lic_rdata,
  input  logic [DATA_W-1:0] ioc_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic [ADDR_W-1:0] masked;
  dec_t              dec;
  shd_code_e         rd_code;
  shd_code_e         wr_code;
  tgt_e              tgt;

  pmr_addr_decode #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .LIC_BASE(LIC_BASE),
    .IOC_BASE(IOC_BASE), .WIN_LOG2(WIN_LOG2)
  ) u_decode (
    .addr(addr), .a20_en(a20_en), .masked(masked), .dec(dec)
  );

  pmr_shadow_lookup u_shadow (
    .rd_tbl(shd_rd_tbl), .wr_tbl(shd_wr_tbl), .seg(dec.seg),
    .rd_code(rd_code), .wr_code(wr_code)
  );

  pmr_route u_route (
    .rd_stb(rd_stb), .wr_stb(wr_stb), .shadow_en(shadow_en), .dec(dec),
    .rd_code(rd_code), .wr_code(wr_code), .tgt(tgt)
  );

  pmr_rdata_reg #(.DATA_W(DATA_W)) u_rdata (
    .clk(clk), .rst(rst), .capture(rd_stb && !wr_stb), .tgt(tgt),
    .ram_rdata(ram_rdata), .vid_rdata(vid_rdata), .rom_rdata(rom_rdata),
    .lic_rdata(lic_rdata), .ioc_rdata(ioc_rdata), .rdata(rdata), .err(err)
  );

  assign tgt_addr  = masked;
  assign tgt_wdata = wdata;
  assign rom_addr  = masked[ROM_AW-1:0];
  assign ram_cs    = (tgt == TGT_RAM);
  assign vid_cs    = (tgt == TGT_VID);
  assign rom_cs    = (tgt == TGT_ROM);
  assign lic_cs    = (tgt == TGT_LIC);
  assign ioc_cs    = (tgt == TGT_IOC);
  assign tgt_we    = wr_stb && (tgt != TGT_NONE) && (tgt != TGT_BAD);
endmodule

// File: rtl/pmr_checker.sv
module pmr_checker #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 32'h0100_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              a20_en,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              tgt_we,
  input logic              ram_cs,
  input logic              vid_cs,
  input logic              rom_cs,
  input logic              lic_cs,
  input logic              ioc_cs,
  input logic [DATA_W-1:0] ram_rdata,
  input logic [DATA_W-1:0] rdata,
  input logic              err
);
  a_r1_a20_masked: assert property (@(posedge clk) disable iff (rst)
    (!a20_en && (rd_stb || wr_stb)) |-> !tgt_addr[20]);

  a_r4_video_route: assert property (@(posedge clk) disable iff (rst)
    (a20_en && (rd_stb || wr_stb) && addr >= 'hA0000 && addr <= 'hBFFFF && addr < MEM_BYTES)
      |-> (vid_cs && !ram_cs));

  a_r7_rom_never_written: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> !tgt_we);

  a_r9_beyond_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && tgt_addr >= MEM_BYTES && !lic_cs && !ioc_cs) |=> (rdata == '1));

  a_r10_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_cs, vid_cs, rom_cs, lic_cs, ioc_cs}));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb || wr_stb) |=> $stable(rdata));

  a_r12_ram_capture: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && ram_cs) |=> (rdata == $past(ram_rdata)));
endmodule

bind pc_mem_router pmr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)
) u_pmr_checker (
  .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .a20_en(a20_en), .tgt_addr(tgt_addr), .tgt_we(tgt_we), .ram_cs(ram_cs),
  .vid_cs(vid_cs), .rom_cs(rom_cs), .lic_cs(lic_cs), .ioc_cs(ioc_cs),
  .ram_rdata(ram_rdata), .rdata(rdata), .err(err)
);

// File: tb/pc_mem_router_bench.sv
module pc_mem_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MEM = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0]  wdata = '0;
  logic        a20_en = 1'b1, shadow_en = 1'b0;
  logic [31:0] shd_rd_tbl = '0, shd_wr_tbl = '0;
  logic [31:0] tgt_addr;
  logic [7:0]  tgt_wdata;
  logic        tgt_we, ram_cs, vid_cs, rom_cs, lic_cs, ioc_cs;
  logic [17:0] rom_addr;
  logic [7:0]  ram_rdata = '0, vid_rdata = '0, rom_rdata = '0, lic_rdata = '0, ioc_rdata = '0;
  logic [7:0]  rdata;
  logic        err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [4:0]  e_cs;
  logic        e_we, e_bad;
  logic [7:0]  e_val;
  logic [31:0] e_ma;
  string       e_tag;
  logic [7:0]  exp_rdata = '0;
  logic        exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_mem_router u_pc_mem_router (
    .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .a20_en(a20_en), .shadow_en(shadow_en),
    .shd_rd_tbl(shd_rd_tbl), .shd_wr_tbl(shd_wr_tbl), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_we(tgt_we), .ram_cs(ram_cs), .vid_cs(vid_cs),
    .rom_cs(rom_cs), .rom_addr(rom_addr), .lic_cs(lic_cs), .ioc_cs(ioc_cs),
    .ram_rdata(ram_rdata), .vid_rdata(vid_rdata), .rom_rdata(rom_rdata),
    .lic_rdata(lic_rdata), .ioc_rdata(ioc_rdata), .rdata(rdata), .err(err)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected routing, computed from the requirement text
  function automatic void model(logic [31:0] a, bit rd, bit wr, bit a20, bit sh);
    logic [31:0] ma;
    logic [1:0]  code;
    int          seg;
    ma = a;
    if (!a20) ma[20] = 1'b0;
    e_ma = ma; e_cs = '0; e_bad = 0; e_val = 8'hFF; e_tag = "R2"; e_we = 0;
    if (!(rd || wr)) begin
      e_tag = "R12";
      return;
    end
    if (ma >= MEM) begin
      if (ma[31:12] == 20'hFEE00) begin e_cs = 5'b00010; e_val = lic_rdata; e_tag = "R10"; end
      else if (ma[31:12] == 20'hFEC00) begin e_cs = 5'b00001; e_val = ioc_rdata; e_tag = "R10"; end
      else e_tag = "R9";
    end else if (ma[31:19] != 13'd1) begin
      e_cs = 5'b10000; e_val = ram_rdata; e_tag = (!a20 && a[20]) ? "R1" : "R2";
    end else if (ma < 32'hA0000) begin
      e_cs = 5'b10000; e_val = ram_rdata; e_tag = "R3";
    end else if (ma < 32'hC0000) begin
      e_cs = 5'b01000; e_val = vid_rdata; e_tag = (!a20 && a[20]) ? "R1" : "R4";
    end else begin
      seg = int'(ma[17:14]);
      if (!sh) begin
        e_tag = "R8";
        if (!wr) begin e_cs = 5'b10000; e_val = ram_rdata; end
      end else begin
        code  = wr ? shd_wr_tbl[2*seg +: 2] : shd_rd_tbl[2*seg +: 2];
        e_tag = wr ? "R6" : "R7";
        if (shd_wr_tbl[2*seg +: 2] != shd_rd_tbl[2*seg +: 2]) e_tag = "R5";
        case (code)
          2'd0: begin e_cs = 5'b10000; e_val = ram_rdata; end
          2'd1: if (!wr) begin e_cs = 5'b00100; e_val = rom_rdata; end
          default: begin e_bad = 1; e_tag = "R11"; end
        endcase
      end
    end
    e_we = wr && (e_cs != 0);
  endfunction

  // Entered at a falling edge; leaves at the next falling edge
  task automatic access(logic [31:0] a, bit rd, bit wr, bit a20, bit sh);
    addr = a; rd_stb = rd; wr_stb = wr; a20_en = a20; shadow_en = sh;
    wdata = 8'($urandom); ram_rdata = 8'($urandom); vid_rdata = 8'($urandom);
    rom_rdata = 8'($urandom); lic_rdata = 8'($urandom); ioc_rdata = 8'($urandom);
    #1;
    model(a, rd, wr, a20, sh);
    chk({ram_cs, vid_cs, rom_cs, lic_cs, ioc_cs} == e_cs, e_tag,
        {ram_cs, vid_cs, rom_cs, lic_cs, ioc_cs}, e_cs);
    chk(tgt_we == e_we, e_tag, tgt_we, e_we);
    chk(tgt_addr == e_ma, (!a20) ? "R1" : e_tag, tgt_addr, e_ma);
    if (e_cs[2]) chk(rom_addr == 18'(e_ma - 32'hC0000), "R7", rom_addr, e_ma - 32'hC0000);
    if (e_we) chk(tgt_wdata == wdata, e_tag, tgt_wdata, wdata);
    if (rd && !wr) exp_rdata = e_val;
    if (e_bad) exp_err = 1'b1;
    @(negedge clk);
    chk(rdata == exp_rdata, (rd && !wr) ? e_tag : "R12", rdata, exp_rdata);
    chk(err == exp_err, "R11", err, exp_err);
    rd_stb = 0; wr_stb = 0;
  endtask

  task automatic do_reset();
    rst = 1; rd_stb = 0; wr_stb = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    exp_rdata = '0; exp_err = 0;
    chk(rdata == 8'h00, "R13", rdata, 8'h00);
    chk(err == 1'b0, "R13", err, 1'b0);
  endtask

  function automatic logic [31:0] rand_tbl(bit allow_bad);
    logic [31:0] t;
    t = $urandom;
    if (!allow_bad) for (int i = 0; i < 16; i++) t[2*i+1] = 1'b0;
    return t;
  endfunction

  function automatic logic [31:0] rand_addr();
    case ($urandom % 8)
      0: return $urandom % 32'h80000;
      1: return 32'h80000 + ($urandom % 32'h20000);
      2: return 32'hA0000 + ($urandom % 32'h20000);
      3: return 32'hC0000 + ($urandom % 32'h40000);
      4: return $urandom % 32'h0200_0000;
      5: return 32'hFEE0_0000 + ($urandom % 32'h2000);
      6: return 32'hFEC0_0000 + ($urandom % 32'h2000);
      default: return $urandom;
    endcase
  endfunction

  task automatic random_phase(int n, bit allow_bad);
    for (int i = 0; i < n; i++) begin
      if (i % 64 == 0) begin
        shd_rd_tbl = rand_tbl(allow_bad);
        shd_wr_tbl = rand_tbl(allow_bad);
      end
      access(rand_addr(), 1'($urandom), 1'($urandom), ($urandom % 4) != 0, 1'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();                                   // R13
    access(32'h0001_2345, 1, 0, 1, 0);            // R2 read
    access(32'h0003_0000, 0, 1, 1, 0);            // R2 write
    access(32'h0008_1234, 1, 0, 1, 0);            // R3
    access(32'h0009_FFFF, 0, 1, 1, 0);            // R3 top edge
    access(32'h000A_0000, 1, 0, 1, 0);            // R4 low edge
    access(32'h000B_FFFF, 0, 1, 1, 0);            // R4 high edge
    // seg0 rd1 wr1, seg1 rd0 wr0, seg2 rd1 wr0, seg3 rd0 wr1
    shd_rd_tbl = 32'h0000_0011; shd_wr_tbl = 32'h0000_0041;
    access(32'h000C_0010, 1, 0, 1, 1);            // R7 ROM read
    access(32'h000C_0010, 0, 1, 1, 1);            // R6 inhibited write
    access(32'h000C_4000, 1, 0, 1, 1);            // R7 code 0
    access(32'h000C_7FFF, 0, 1, 1, 1);            // R6 code 0
    access(32'h000C_8123, 1, 0, 1, 1);            // R5 ROM read
    access(32'h000C_8123, 0, 1, 1, 1);            // R5 RAM write
    access(32'h000C_C000, 1, 0, 1, 1);            // R5 RAM read
    access(32'h000C_C000, 0, 1, 1, 1);            // R5 dropped write
    access(32'h000F_FFFF, 1, 0, 1, 1);            // R7 last segment
    access(32'h000E_0000, 1, 0, 1, 0);            // R8 read
    access(32'h000E_0000, 0, 1, 1, 0);            // R8 write
    access(32'h001A_0000, 1, 0, 0, 0);            // R1 alias to video
    access(32'h0010_0000, 0, 1, 0, 0);            // R1 alias to 0
    access(32'h0010_0000, 0, 1, 1, 0);            // R2 no alias
    access(32'h00FF_FFFF, 1, 0, 1, 0);            // R2 last byte
    access(32'h0100_0000, 1, 0, 1, 0);            // R9 first byte past
    access(32'h0200_0000, 0, 1, 1, 0);            // R9 write
    access(32'hFEE0_0020, 1, 0, 1, 0);            // R10 local window
    access(32'hFEC0_0010, 0, 1, 1, 0);            // R10 I/O window
    access(32'hFEE0_1000, 1, 0, 1, 0);            // R9 just past window
    access(32'h0000_0012, 1, 1, 1, 0);            // R12 both strobes
    access(32'h0000_0012, 0, 0, 1, 0);            // R12 idle
    random_phase(3000, 0);
    // reserved codes
    do_reset();
    shd_rd_tbl = 32'h0000_0C00; shd_wr_tbl = 32'h0000_0800;   // seg5: rd3, wr2
    access(32'h000D_4000, 0, 1, 1, 1);            // R11 write, code 2
    access(32'h000D_4001, 1, 0, 1, 1);            // R11 read, code 3
    access(32'h0000_0100, 1, 0, 1, 1);            // R11 flag stays set
    random_phase(2000, 1);
    do_reset();                                   // R13 clears flag
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule